// File: doc/BRIEF.md
# CAN Operating-Mode Manager

This block sits between a CAN protocol core and the bus pins. It sequences the low-power state and the self-test modes. It also decides what the core sees on its receive input and what reaches the transmit pin. Software drives a sleep request, an init request, an automatic-wake enable, a wake interrupt enable and two test-mode selects. The block returns sleep and init acknowledge flags, a one-cycle wake interrupt and a clock enable for the core. When the core transmits to itself, an ignore-acknowledge-error flag goes high.

The sleep request bit is stored here, because hardware must be able to clear it on an automatic wake. Bus activity is a dominant level on the receive pin. It is passed through a synchroniser and then sampled while asleep. Once the sleep bit clears, the block waits for a run of recessive bit samples before it drops the sleep acknowledge. The sample points come from the core's bit timing on `samp_en`.

Top module: `can_mode_mgr`

## Requirements
- R1: During and right after reset, sleep_ack, init_ack and wake_irq are 0, core_clk_en is 1 and tx_pin is recessive (1) while core_tx is 1.
- R2: Writing 1 to the sleep bit from the normal state raises sleep_ack and lowers core_clk_en two clock edges after the write edge.
- R3: While sleep_ack is high, init_req is not acknowledged and init_ack stays 0.
- R4: With auto_wake_en = 1, a dominant (0) rx_pin in sleep clears sleep_flag on the third clock edge after the pin change. sleep_ack stays high at that point.
- R5: With auto_wake_en = 0, bus activity in sleep leaves sleep_flag and sleep_ack set until software writes 0 to the sleep bit.
- R6: wake_irq is a one-cycle pulse on the third edge after rx_pin goes dominant in sleep, whether or not auto-wake is on. It fires at most once per sleep period and never when wake_irq_en is 0.
- R7: Software writing 0 to the sleep bit clears sleep_flag and starts bus synchronisation.
- R8: After sleep_flag clears, sleep_ack falls only after IDLE_BITS consecutive samples (samp_en high) of a recessive rx. A dominant sample restarts the count. IDLE_BITS defaults to 11.
- R9: The silent and loop-back selects are captured only while init_ack is high. Changes made outside init have no effect on the pins.
- R10: init_ack rises one edge after init_req is raised in the normal state, and it falls one edge after init_req is dropped.
- R11: In normal mode tx_pin = core_tx and core_rx = rx_pin. In silent mode tx_pin = 1 and core_rx = core_tx AND rx_pin.
- R12: In loop-back mode core_rx = core_tx, tx_pin = core_tx and ign_ack_err = 1. With both modes on, tx_pin = 1 and core_rx = core_tx.
- R13: tx_allow is 1 only in the normal state with silent mode off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_sleep_wr | input | 1 | Write strobe for the sleep bit |
| sw_sleep_val | input | 1 | Value written to the sleep bit |
| init_req | input | 1 | Initialisation request level |
| auto_wake_en | input | 1 | Hardware clears the sleep bit on bus activity |
| wake_irq_en | input | 1 | Enables the wake interrupt |
| silent_sel | input | 1 | Silent mode select |
| loop_sel | input | 1 | Loop-back mode select |
| samp_en | input | 1 | Bit sample point strobe from the core |
| rx_pin | input | 1 | Bus receive pin |
| core_tx | input | 1 | Transmit bit from the protocol core |
| tx_pin | output | 1 | Bus transmit pin |
| core_rx | output | 1 | Receive bit to the protocol core |
| sleep_flag | output | 1 | Current sleep bit |
| sleep_ack | output | 1 | Sleep acknowledge |
| init_ack | output | 1 | Init acknowledge |
| wake_irq | output | 1 | Wake interrupt pulse |
| core_clk_en | output | 1 | Core clock enable |
| ign_ack_err | output | 1 | Suppress acknowledge-slot errors |
| tx_allow | output | 1 | Core may start a transmission |

## Verification
The bench uses the default parameters: a two-stage synchroniser and an eleven-sample idle run. This makes the three-edge wake latency and the exact sample that releases sleep_ack directly countable. The bench strobes samp_en one edge at a time. It can therefore place a dominant sample in the middle of the idle run and show that the count restarts.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
   typedef enum logic [1:0] {
      MS_NORMAL = 2'd0,
      MS_INIT   = 2'd1,
      MS_SLEEP  = 2'd2,
      MS_SYNC   = 2'd3
   } mode_state_e;

   localparam logic BUS_RECESSIVE = 1'b1;
   localparam logic BUS_DOMINANT  = 1'b0;
endpackage

// File: rtl/cmm_sync.sv
module cmm_sync #(
   parameter int  STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("cmm_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RESET_VAL;
               else        chain_q[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= RESET_VAL;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/cmm_sleep_ctl.sv
module cmm_sleep_ctl
   import can_mode_pkg::*;
#(
   parameter int IDLE_BITS = 11
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sw_sleep_wr,
   input  logic        sw_sleep_val,
   input  logic        init_req,
   input  logic        auto_wake_en,
   input  logic        wake_irq_en,
   input  logic        samp_en,
   input  logic        rx_sync,
   output mode_state_e state,
   output logic        sleep_bit,
   output logic        wake_irq
);
   localparam int CNT_W = $clog2(IDLE_BITS + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_BITS - 1);

   generate
      if (IDLE_BITS < 1) begin : g_bad
         $error("cmm_sleep_ctl: IDLE_BITS must be at least 1");
      end
   endgenerate

   mode_state_e      state_q, state_d;
   logic             sleep_q;
   logic             act_seen_q;
   logic             irq_q;
   logic [CNT_W-1:0] idle_cnt_q;
   logic             wake_evt;
   logic             idle_done;

   assign wake_evt  = (state_q == MS_SLEEP) && (rx_sync == BUS_DOMINANT) && !act_seen_q;
   assign idle_done = (state_q == MS_SYNC) && samp_en && (rx_sync == BUS_RECESSIVE)
                      && (idle_cnt_q == CNT_LAST);

   // sleep bit: hardware clear on auto wake wins over a software write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       sleep_q <= 1'b0;
      else if (wake_evt && auto_wake_en) sleep_q <= 1'b0;
      else if (sw_sleep_wr)              sleep_q <= sw_sleep_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_seen_q <= 1'b0;
         irq_q      <= 1'b0;
      end else begin
         irq_q <= wake_evt && wake_irq_en;
         if (state_q != MS_SLEEP) act_seen_q <= 1'b0;
         else if (wake_evt)       act_seen_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_cnt_q <= '0;
      end else if (state_q != MS_SYNC) begin
         idle_cnt_q <= '0;
      end else if (samp_en) begin
         if (rx_sync == BUS_RECESSIVE) begin
            if (idle_cnt_q != CNT_LAST) idle_cnt_q <= idle_cnt_q + 1'b1;
         end else begin
            idle_cnt_q <= '0;
         end
      end
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         MS_NORMAL: begin
            if (sleep_q)       state_d = MS_SLEEP;
            else if (init_req) state_d = MS_INIT;
         end
         MS_INIT: begin
            if (sleep_q)        state_d = MS_SLEEP;
            else if (!init_req) state_d = MS_NORMAL;
         end
         MS_SLEEP: begin
            if (!sleep_q) state_d = MS_SYNC;
         end
         MS_SYNC: begin
            if (sleep_q)        state_d = MS_SLEEP;
            else if (idle_done) state_d = MS_NORMAL;
         end
         default: state_d = MS_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= MS_NORMAL;
      else        state_q <= state_d;
   end

   assign state     = state_q;
   assign sleep_bit = sleep_q;
   assign wake_irq  = irq_q;
endmodule

// File: rtl/cmm_path_mux.sv
module cmm_path_mux
   import can_mode_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic in_init,
   input  logic silent_sel,
   input  logic loop_sel,
   input  logic rx_pin,
   input  logic core_tx,
   output logic silent_on,
   output logic loop_on,
   output logic tx_pin,
   output logic core_rx
);
   logic silent_q, loop_q;

   // test-mode selects are sampled only while initialising
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         silent_q <= 1'b0;
         loop_q   <= 1'b0;
      end else if (in_init) begin
         silent_q <= silent_sel;
         loop_q   <= loop_sel;
      end
   end

   always_comb begin
      tx_pin  = silent_q ? BUS_RECESSIVE : core_tx;
      if (loop_q)        core_rx = core_tx;
      else if (silent_q) core_rx = core_tx & rx_pin;
      else               core_rx = rx_pin;
   end

   assign silent_on = silent_q;
   assign loop_on   = loop_q;
endmodule

// File: rtl/can_mode_mgr.sv
module can_mode_mgr
   import can_mode_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int IDLE_BITS   = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_sleep_wr,
   input  logic sw_sleep_val,
   input  logic init_req,
   input  logic auto_wake_en,
   input  logic wake_irq_en,
   input  logic silent_sel,
   input  logic loop_sel,
   input  logic samp_en,
   input  logic rx_pin,
   input  logic core_tx,
   output logic tx_pin,
   output logic core_rx,
   output logic sleep_flag,
   output logic sleep_ack,
   output logic init_ack,
   output logic wake_irq,
   output logic core_clk_en,
   output logic ign_ack_err,
   output logic tx_allow
);
   mode_state_e state;
   logic        rx_sync;
   logic        silent_on, loop_on;

   cmm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(BUS_RECESSIVE)) u_rx_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (rx_pin),
      .q_out (rx_sync)
   );

   cmm_sleep_ctl #(.IDLE_BITS(IDLE_BITS)) u_sleep (
      .clk          (clk),
      .rst_n        (rst_n),
      .sw_sleep_wr  (sw_sleep_wr),
      .sw_sleep_val (sw_sleep_val),
      .init_req     (init_req),
      .auto_wake_en (auto_wake_en),
      .wake_irq_en  (wake_irq_en),
      .samp_en      (samp_en),
      .rx_sync      (rx_sync),
      .state        (state),
      .sleep_bit    (sleep_flag),
      .wake_irq     (wake_irq)
   );

   cmm_path_mux u_path (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_init    (state == MS_INIT),
      .silent_sel (silent_sel),
      .loop_sel   (loop_sel),
      .rx_pin     (rx_pin),
      .core_tx    (core_tx),
      .silent_on  (silent_on),
      .loop_on    (loop_on),
      .tx_pin     (tx_pin),
      .core_rx    (core_rx)
   );

   assign sleep_ack   = (state == MS_SLEEP) || (state == MS_SYNC);
   assign init_ack    = (state == MS_INIT);
   assign core_clk_en = (state != MS_SLEEP);
   assign ign_ack_err = loop_on;
   assign tx_allow    = (state == MS_NORMAL) && !silent_on;
endmodule

// File: rtl/can_mode_mgr_chk.sv
module can_mode_mgr_chk (
   input logic clk,
   input logic rst_n,
   input logic wake_irq_en,
   input logic core_tx,
   input logic tx_pin,
   input logic core_rx,
   input logic sleep_flag,
   input logic sleep_ack,
   input logic init_ack,
   input logic wake_irq,
   input logic core_clk_en,
   input logic ign_ack_err
);
   AST_GATED_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !core_clk_en |-> sleep_ack);                                  // R2
   AST_NO_INIT_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_ack |-> !init_ack);                                     // R3
   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |=> !wake_irq);                                      // R6
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_irq) |-> $past(wake_irq_en));                      // R6
   AST_ACK_DROP_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep_ack) |-> !sleep_flag);                            // R8
   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_ack && !$past(init_ack)) |-> $stable(ign_ack_err));    // R9
   AST_DOMINANT_FROM_CORE: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_pin |-> !core_tx);                                        // R11
   AST_LOOP_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      ign_ack_err |-> (core_rx == core_tx));                        // R12
endmodule

bind can_mode_mgr can_mode_mgr_chk u_chk (.*);

// File: tb/can_mode_mgr_tb.sv
`timescale 1ns/1ps
module can_mode_mgr_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_sleep_wr = 0, sw_sleep_val = 0, init_req = 0;
   logic auto_wake_en = 0, wake_irq_en = 0, silent_sel = 0, loop_sel = 0;
   logic samp_en = 0, rx_pin = 1, core_tx = 1;
   logic tx_pin, core_rx, sleep_flag, sleep_ack, init_ack, wake_irq;
   logic core_clk_en, ign_ack_err, tx_allow;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   can_mode_mgr u_dut (.*);

   // {silent, loop, core_tx, rx_pin, expected tx_pin, expected core_rx}
   localparam logic [5:0] VEC [16] = '{
      6'b000000, 6'b000101, 6'b001010, 6'b001111,
      6'b100010, 6'b100110, 6'b101010, 6'b101111,
      6'b010000, 6'b010100, 6'b011011, 6'b011111,
      6'b110010, 6'b110110, 6'b111011, 6'b111111
   };

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic sw_sleep(input logic v);
      sw_sleep_wr = 1; sw_sleep_val = v;
      tick(1);
      sw_sleep_wr = 0;
   endtask

   task automatic samp(input int n);
      repeat (n) begin
         samp_en = 1; tick(1); samp_en = 0;
      end
   endtask

   task automatic set_mode(input logic s, input logic l);
      init_req = 1; tick(1);
      silent_sel = s; loop_sel = l; tick(1);
      init_req = 0; tick(1);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      tick(2);
      chk("R1 sleep_ack", sleep_ack, 0);
      chk("R1 init_ack", init_ack, 0);
      chk("R1 clk_en", core_clk_en, 1);
      rst_n = 1; tick(1);
      chk("R1 wake_irq", wake_irq, 0);
      chk("R1 tx_pin", tx_pin, 1);

      // mux vector table R11 R12 R13
      for (int i = 0; i < 16; i++) begin
         if (i % 4 == 0) set_mode(VEC[i][5], VEC[i][4]);
         core_tx = VEC[i][3]; rx_pin = VEC[i][2];
         #1;
         chk("R11/R12 tx_pin", tx_pin, VEC[i][1]);
         chk("R11/R12 core_rx", core_rx, VEC[i][0]);
         chk("R12 ign_ack_err", ign_ack_err, VEC[i][4]);
         chk("R13 tx_allow", tx_allow, !VEC[i][5]);
      end
      set_mode(0, 0);
      core_tx = 1; rx_pin = 1;

      // R9: select changes outside init are ignored
      silent_sel = 1; loop_sel = 1; tick(2);
      core_tx = 0; rx_pin = 1; #1;
      chk("R9 tx_pin", tx_pin, 0);
      chk("R9 core_rx", core_rx, 1);
      chk("R9 ign_ack_err", ign_ack_err, 0);
      silent_sel = 0; loop_sel = 0; core_tx = 1; tick(1);

      // R10 init handshake
      init_req = 1; tick(1);
      chk("R10 init_ack rise", init_ack, 1);
      chk("R13 tx_allow in init", tx_allow, 0);
      init_req = 0; tick(1);
      chk("R10 init_ack fall", init_ack, 0);

      // R2 sleep entry
      sw_sleep(1);
      chk("R2 ack after 1 edge", sleep_ack, 0);
      tick(1);
      chk("R2 sleep_ack", sleep_ack, 1);
      chk("R2 clk gated", core_clk_en, 0);

      // R3 init lockout
      init_req = 1; tick(3);
      chk("R3 init_ack", init_ack, 0);
      init_req = 0;

      // R4 R6 auto wake with interrupt
      auto_wake_en = 1; wake_irq_en = 1;
      rx_pin = 0; tick(2);
      chk("R6 irq not yet", wake_irq, 0);
      tick(1);
      chk("R6 irq pulse", wake_irq, 1);
      chk("R4 sleep_flag cleared", sleep_flag, 0);
      chk("R4 ack held", sleep_ack, 1);
      rx_pin = 1; tick(1);
      chk("R6 irq one cycle", wake_irq, 0);

      // R8 sync run with restart
      tick(4);
      chk("R8 no samples", sleep_ack, 1);
      samp(5);
      rx_pin = 0; tick(3); samp(1);
      rx_pin = 1; tick(3);
      samp(10);
      chk("R8 ack after 10", sleep_ack, 1);
      samp(1);
      chk("R8 ack after 11", sleep_ack, 0);
      chk("R8 clk_en", core_clk_en, 1);

      // R5 manual wake, R6 once per sleep, R7 software wake
      auto_wake_en = 0;
      sw_sleep(1); tick(1);
      rx_pin = 0; tick(3);
      chk("R6 irq manual", wake_irq, 1);
      chk("R5 sleep_flag kept", sleep_flag, 1);
      rx_pin = 1; tick(20);
      chk("R5 ack kept", sleep_ack, 1);
      rx_pin = 0; tick(3);
      chk("R6 no second irq", wake_irq, 0);
      rx_pin = 1; tick(3);
      sw_sleep(0);
      chk("R7 sleep_flag", sleep_flag, 0);
      chk("R7 ack in sync", sleep_ack, 1);
      tick(1); samp(11);
      chk("R7 ack released", sleep_ack, 0);

      // R6 interrupt disabled
      auto_wake_en = 1; wake_irq_en = 0;
      sw_sleep(1); tick(1);
      rx_pin = 0; tick(3);
      chk("R6 irq masked", wake_irq, 0);
      chk("R4 auto clear", sleep_flag, 0);
      rx_pin = 1; tick(3); samp(11);
      chk("R8 ack released", sleep_ack, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule